// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system read and write a byte-wide asynchronous static RAM. The user side offers a single-transfer request/ready handshake: when `ready_o` is high, a pulse on `req_i` with `wr_i`, `addr_i` and `wdata_i` starts one access. A read result comes back on `rdata_o` together with a one-cycle `rvalid_o` strobe. The memory side drives the address, active-low chip select, output enable and write strobe, and a split data bus (`mem_dq_o`, `mem_dq_i`, `mem_dq_oe_o`) that the pad ring joins into one bidirectional bus.

Every timing minimum of the memory is a nanosecond parameter. The controller converts each one into a cycle count by ceiling division by the clock period, with a floor of one cycle. Read and write use separate counts. Two further intervals keep the shared data bus free of contention. After a read, the controller waits until the memory's outputs have had time to float before it returns to idle. During a write, the controller enables its drivers only after the memory has had time to release the bus following the fall of the write strobe.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and after its release, `ready_o` is 1, all three memory strobes are 1 (inactive), `mem_dq_oe_o` is 0 and `rvalid_o` is 0.
- R2: A request is taken only on a clock edge where `req_i` and `ready_o` are both 1. `ready_o` falls on that edge and stays 0 until the access ends. Any request presented while `ready_o` is 0 has no effect on the memory.
- R3: A read holds chip select and output enable low, and the write strobe high, for RD cycles from the accepting edge. RD is the larger of 2 and the ceiling of the longest read access or read cycle time divided by the clock period (10 with defaults). The data bus is sampled on the edge that ends this window, and `rvalid_o` is 1 for exactly the following cycle.
- R4: After a read, the controller waits OHZ = ceil(output-float time / period) cycles (4 with defaults) before `ready_o` returns, so it returns RD+OHZ cycles after acceptance.
- R5: A write drops chip select one cycle before the write strobe. Output enable stays high throughout. Chip select rises on the same edge as the write strobe, after 1+PULSE cycles low.
- R6: The write strobe is low for PULSE cycles. PULSE is the maximum of three values: the ceiling of the write pulse width, WHZ plus the ceiling of the data setup, and the ceiling of the select/address-to-end time minus one (7 with defaults; WHZ = 3). The controller drives the bus only after WHZ cycles of strobe low, keeps driving to the end of the pulse (PULSE−WHZ cycles), and stops on the edge where the strobe rises.
- R7: The memory address stays constant from acceptance until `ready_o` returns. A write returns to idle after 1+PULSE+REC cycles, where REC = max(1, ceil(write cycle/period) − 1 − PULSE), so the address is held for at least the write cycle time.
- R8: The byte driven during a write equals the accepted `wdata_i`. A later read of that address returns it on `rdata_o`.
- R9: The controller never drives the data bus while output enable is low or while the memory may still be driving. With chip select high, both other strobes are high.
- R10: Every cycle count above is derived from the nanosecond parameters by ceiling division with a minimum of one cycle, with no further constant added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Access address |
| wdata_i | input | DATA_W | Write byte |
| ready_o | output | 1 | Idle, may accept a request |
| rvalid_o | output | 1 | Read data valid, one cycle |
| rdata_o | output | DATA_W | Read byte |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_ce_no | output | 1 | Memory chip select, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_we_no | output | 1 | Memory write strobe, active low |
| mem_dq_o | output | DATA_W | Data toward memory |
| mem_dq_i | input | DATA_W | Data from memory |
| mem_dq_oe_o | output | 1 | Drive enable for the data bus |

## Verification
The hardest situations to reach from the ports are the bus handovers: a write issued on the first idle cycle after a read, and a read sampled one cycle too early. The bench's memory model holds its outputs active for the float interval after a read. It also returns inverted data until the access time has elapsed, so a shortened turnaround shows up as contention and a shortened read window shows up as wrong data. The sweep runs many read-after-write and write-after-read pairs back to back, including the top and bottom addresses. In a separate case, a conflicting write request is held on `req_i` throughout a busy read and then withdrawn. A later read-back confirms that this request left the memory unchanged.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_ACCESS, ST_RD_CAPTURE, ST_WR_SETUP,
    ST_WR_PULSE, ST_WR_RECOVER, ST_TURN
  } state_e;

  function automatic int ns2cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
`timescale 1ns/1ps
module sram_ctrl_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_LEN_C = 10,
  parameter int OHZ_C    = 4,
  parameter int WHZ_C    = 3,
  parameter int PULSE_C  = 7,
  parameter int REC_C    = 1,
  parameter int CNT_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             ready_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             ce_n_o,
  output logic             oe_n_o,
  output logic             we_n_o,
  output logic             dq_oe_o
);
  localparam logic [CNT_W-1:0] RdLoad  = CNT_W'(RD_LEN_C - 2);
  localparam logic [CNT_W-1:0] OhzLoad = CNT_W'(OHZ_C - 1);
  localparam logic [CNT_W-1:0] PulLoad = CNT_W'(PULSE_C - 1);
  localparam logic [CNT_W-1:0] RecLoad = CNT_W'(REC_C - 1);
  localparam logic [CNT_W-1:0] DrvLim  = CNT_W'(PULSE_C - WHZ_C);

  state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    case (state_q)
      ST_IDLE: if (req_i) begin
        load_o = 1'b1;
        if (wr_i) state_d = ST_WR_SETUP;
        else begin
          state_d    = ST_RD_ACCESS;
          load_val_o = RdLoad;
        end
      end
      ST_RD_ACCESS:  if (cnt_zero_i) state_d = ST_RD_CAPTURE;
      ST_RD_CAPTURE: begin
        state_d    = ST_TURN;
        load_o     = 1'b1;
        load_val_o = OhzLoad;
      end
      ST_TURN:       if (cnt_zero_i) state_d = ST_IDLE;
      ST_WR_SETUP: begin
        state_d    = ST_WR_PULSE;
        load_o     = 1'b1;
        load_val_o = PulLoad;
      end
      ST_WR_PULSE: if (cnt_zero_i) begin
        state_d    = ST_WR_RECOVER;
        load_o     = 1'b1;
        load_val_o = RecLoad;
      end
      ST_WR_RECOVER: if (cnt_zero_i) state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  assign ready_o   = (state_q == ST_IDLE);
  assign accept_o  = ready_o && req_i;
  assign capture_o = (state_q == ST_RD_CAPTURE);
  assign oe_n_o    = !(state_q inside {ST_RD_ACCESS, ST_RD_CAPTURE});
  assign ce_n_o    = !(state_q inside {ST_RD_ACCESS, ST_RD_CAPTURE, ST_WR_SETUP, ST_WR_PULSE});
  assign we_n_o    = (state_q != ST_WR_PULSE);
  // drive only once the memory has had WHZ cycles to float its outputs
  assign dq_oe_o   = (state_q == ST_WR_PULSE) && (cnt_i < DrvLim);
endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W         = 19,
  parameter int DATA_W         = 8,
  parameter int CLK_NS         = 10,
  parameter int RD_CYCLE_NS    = 100,
  parameter int ADDR_ACC_NS    = 100,
  parameter int CE_ACC_NS      = 100,
  parameter int OE_ACC_NS      = 45,
  parameter int OE_HIZ_NS      = 35,
  parameter int WR_CYCLE_NS    = 70,
  parameter int CE_TO_END_NS   = 60,
  parameter int ADDR_TO_END_NS = 60,
  parameter int WE_PULSE_NS    = 50,
  parameter int DATA_SETUP_NS  = 35,
  parameter int WE_HIZ_NS      = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe_o
);
  localparam int RdAccNs = imax(imax(RD_CYCLE_NS, ADDR_ACC_NS), imax(CE_ACC_NS, OE_ACC_NS));
  localparam int RdLenC  = imax(2, ns2cyc(RdAccNs, CLK_NS));
  localparam int OhzC    = ns2cyc(OE_HIZ_NS, CLK_NS);
  localparam int WhzC    = ns2cyc(WE_HIZ_NS, CLK_NS);
  localparam int PulseC  = imax(imax(ns2cyc(WE_PULSE_NS, CLK_NS),
                                     WhzC + ns2cyc(DATA_SETUP_NS, CLK_NS)),
                                ns2cyc(imax(CE_TO_END_NS, ADDR_TO_END_NS), CLK_NS) - 1);
  localparam int RecC    = imax(1, ns2cyc(WR_CYCLE_NS, CLK_NS) - 1 - PulseC);
  localparam int CntW    = $clog2(imax(imax(RdLenC, OhzC), imax(PulseC, RecC)) + 1);

  logic            load, cnt_zero, accept, capture;
  logic [CntW-1:0] load_val, cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q;

  sram_ctrl_timer #(.W(CntW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .val_i  (load_val),
    .cnt_o  (cnt),
    .zero_o (cnt_zero)
  );

  sram_ctrl_fsm #(
    .RD_LEN_C (RdLenC),
    .OHZ_C    (OhzC),
    .WHZ_C    (WhzC),
    .PULSE_C  (PulseC),
    .REC_C    (RecC),
    .CNT_W    (CntW)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .wr_i       (wr_i),
    .cnt_i      (cnt),
    .cnt_zero_i (cnt_zero),
    .load_o     (load),
    .load_val_o (load_val),
    .ready_o    (ready_o),
    .accept_o   (accept),
    .capture_o  (capture),
    .ce_n_o     (mem_ce_no),
    .oe_n_o     (mem_oe_no),
    .we_n_o     (mem_we_no),
    .dq_oe_o    (mem_dq_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture;
      if (accept) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (capture) rdata_q <= mem_dq_i;
    end
  end

  assign mem_addr_o = addr_q;
  assign mem_dq_o   = wdata_q;
  assign rdata_o    = rdata_q;
  assign rvalid_o   = rvalid_q;
endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
module sram_ctrl_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ready_o,
  input logic              rvalid_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ce_no,
  input logic              mem_oe_no,
  input logic              mem_we_no,
  input logic              mem_dq_oe_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (mem_ce_no && mem_oe_no && mem_we_no && !mem_dq_oe_o));

  p_accept_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && req_i) |=> !ready_o);

  p_rvalid_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  p_ce_before_we_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |-> $past(!mem_ce_no));

  p_no_drive_at_we_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |-> !mem_dq_oe_o);

  p_release_with_we_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> !mem_dq_oe_o);

  p_addr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && $past(!ready_o)) |-> $stable(mem_addr_o));

  p_no_contention_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (mem_oe_no && !mem_we_no));

  p_deselect_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ce_no |-> (mem_we_no && mem_oe_no));
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .ready_o     (ready_o),
  .rvalid_o    (rvalid_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ce_no   (mem_ce_no),
  .mem_oe_no   (mem_oe_no),
  .mem_we_no   (mem_we_no),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;
  localparam int CLK_NS = 10;
  localparam int HALF   = CLK_NS / 2;
  localparam int T_RC = 100, T_AA = 100, T_ACE = 100, T_OE = 45, T_OHZ = 35;
  localparam int T_WC = 70, T_CW = 60, T_AW = 60, T_WP = 50, T_DS = 35, T_WHZ = 25;

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R10: expected counts from the ns figures
  localparam int E_RD    = mx(2, cdiv(mx(mx(T_RC, T_AA), mx(T_ACE, T_OE))));
  localparam int E_OHZ   = cdiv(T_OHZ);
  localparam int E_WHZ   = cdiv(T_WHZ);
  localparam int E_PULSE = mx(mx(cdiv(T_WP), E_WHZ + cdiv(T_DS)), cdiv(mx(T_CW, T_AW)) - 1);
  localparam int E_REC   = mx(1, cdiv(T_WC) - 1 - E_PULSE);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready, rvalid;
  logic [7:0]  rdata;
  logic [18:0] m_addr;
  logic        m_ce_n, m_oe_n, m_we_n, m_dq_oe;
  logic [7:0]  m_dq_o, m_dq_i;
  logic [7:0]  m_data = 8'h00;

  int n_chk = 0, n_err = 0, cyc = 0;
  logic armed = 1'b0;

  always #HALF clk = ~clk;

  assign m_dq_i = m_dq_oe ? m_dq_o : m_data;

  sram_ctrl #(
    .ADDR_W(19), .DATA_W(8), .CLK_NS(CLK_NS),
    .RD_CYCLE_NS(T_RC), .ADDR_ACC_NS(T_AA), .CE_ACC_NS(T_ACE), .OE_ACC_NS(T_OE),
    .OE_HIZ_NS(T_OHZ), .WR_CYCLE_NS(T_WC), .CE_TO_END_NS(T_CW), .ADDR_TO_END_NS(T_AW),
    .WE_PULSE_NS(T_WP), .DATA_SETUP_NS(T_DS), .WE_HIZ_NS(T_WHZ)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready), .rvalid_o(rvalid), .rdata_o(rdata),
    .mem_addr_o(m_addr), .mem_ce_no(m_ce_n), .mem_oe_no(m_oe_n), .mem_we_no(m_we_n),
    .mem_dq_o(m_dq_o), .mem_dq_i(m_dq_i), .mem_dq_oe_o(m_dq_oe)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_err++;
      $display("FAIL watchdog R2: actual %0d cycles expected < 100000", cyc);
      finish_run();
    end
  end

  // ---- memory model: timing checks at negedges, data only after access time
  logic [7:0] mem [logic [18:0]];
  logic [7:0] exp_mem [logic [18:0]];

  function automatic logic [7:0] mem_rd(input logic [18:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  function automatic logic [7:0] exp_rd(input logic [18:0] a);
    return exp_mem.exists(a) ? exp_mem[a] : 8'h00;
  endfunction

  logic        p_ce_n = 1'b1, p_we_n = 1'b1, p_dq_oe = 1'b0, p_rd = 1'b0;
  logic [18:0] p_addr = '0;
  logic [7:0]  lat = '0;
  logic        drv_seen = 1'b0, last_wr = 1'b0, op_seen = 1'b0;
  longint      t_wf = 0, t_d = 0, t_cf = 0, t_acc = 0, t_off = -1000, t_addr = 0;

  always @(negedge clk) begin
    longint now;
    logic   rd;
    now = longint'($time) - HALF;   // events happened at the preceding posedge
    rd  = !m_ce_n && !m_oe_n && m_we_n;
    if (armed) begin
      if (m_addr != p_addr) begin
        if (!p_ce_n && !m_ce_n) chk(1'b0, "R7", "address moved while selected", 1, 0);
        if (op_seen) chk(now - t_addr >= (last_wr ? T_WC : T_RC), "R7", "address cycle ns",
                         now - t_addr, last_wr ? T_WC : T_RC);
        t_addr = now;
      end
      if (p_we_n && !m_we_n) begin
        t_wf = now; drv_seen = 1'b0; last_wr = 1'b1; op_seen = 1'b1;
        chk(!m_ce_n, "R5", "ce low at write strobe fall", m_ce_n, 0);
      end
      if (!p_dq_oe && m_dq_oe) begin
        t_d = now;
        chk(now - t_wf >= T_WHZ && !m_we_n, "R6", "drive start after strobe fall ns", now - t_wf, T_WHZ);
      end
      if (m_dq_oe) begin lat = m_dq_o; drv_seen = 1'b1; end
      if (!p_we_n && m_we_n) begin
        chk(now - t_wf >= T_WP, "R6", "write pulse ns", now - t_wf, T_WP);
        chk(drv_seen && now - t_d >= T_DS, "R6", "data setup ns", drv_seen ? now - t_d : -1, T_DS);
        chk(now - t_cf >= T_CW, "R5", "select to end of write ns", now - t_cf, T_CW);
        if (drv_seen) mem[m_addr] = lat;
      end
      if (p_ce_n && !m_ce_n) t_cf = now;
      if (!p_rd && rd) begin t_acc = now; last_wr = 1'b0; op_seen = 1'b1; end
      if (p_rd && !rd) begin
        chk(now - t_acc >= T_RC, "R3", "read select window ns", now - t_acc, T_RC);
        t_off = now;
      end
      if (m_dq_oe)
        chk(!(rd || now - t_off < T_OHZ), "R9", "bus contention with memory outputs",
            now - t_off, T_OHZ);
    end
    // valid if the access time is reached by the next rising edge
    m_data  = (rd && now + CLK_NS - t_acc >= T_AA) ? mem_rd(m_addr) : ~mem_rd(m_addr);
    p_ce_n  = m_ce_n; p_we_n = m_we_n; p_dq_oe = m_dq_oe; p_rd = rd; p_addr = m_addr;
  end

  // ---- one access, measured from the accepting edge (negedge index 0 follows it)
  task automatic run_op(input bit w, input logic [18:0] a, input logic [7:0] d,
                        input bit poke, input logic [18:0] pa);
    int k, ce_cnt, we_cnt, drv_cnt, rv_idx, bad_drv;
    logic [7:0] rd_val;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    if (poke) begin
      wr = 1'b1; addr = pa; wdata = ~d;     // conflicting request during busy
    end else req = 1'b0;
    k = 0; ce_cnt = 0; we_cnt = 0; drv_cnt = 0; rv_idx = -1; bad_drv = 0; rd_val = '0;
    while (1) begin
      if (!m_ce_n) ce_cnt++;
      if (!m_we_n) we_cnt++;
      if (m_dq_oe) begin drv_cnt++; if (m_dq_o != d) bad_drv++; end
      if (rvalid) begin
        if (rv_idx >= 0) chk(1'b0, "R3", "rvalid longer than one cycle", k, rv_idx);
        rv_idx = k; rd_val = rdata;
      end
      if (ready) break;
      if (poke && k == E_RD + E_OHZ - 2) req = 1'b0;
      k++;
      @(negedge clk);
    end
    if (w) begin
      exp_mem[a] = d;
      chk(k == 1 + E_PULSE + E_REC, "R7", "write busy cycles", k, 1 + E_PULSE + E_REC);
      chk(we_cnt == E_PULSE, "R6", "strobe low cycles (R10 count)", we_cnt, E_PULSE);
      chk(drv_cnt == E_PULSE - E_WHZ, "R6", "drive cycles", drv_cnt, E_PULSE - E_WHZ);
      chk(ce_cnt == 1 + E_PULSE, "R5", "select low cycles", ce_cnt, 1 + E_PULSE);
      chk(bad_drv == 0, "R8", "driven byte mismatches", bad_drv, 0);
    end else begin
      chk(rv_idx == E_RD, "R3", "rvalid cycle (R10 count)", rv_idx, E_RD);
      chk(k == E_RD + E_OHZ, "R4", "read busy cycles", k, E_RD + E_OHZ);
      chk(ce_cnt == E_RD && we_cnt == 0, "R3", "read select cycles", ce_cnt, E_RD);
      chk(drv_cnt == 0, "R9", "drive during read", drv_cnt, 0);
      chk(rd_val == exp_rd(a), "R8", "read data", rd_val, exp_rd(a));
    end
  endtask

  function automatic logic [18:0] addr_of(input int i);
    if (i == 0) return 19'h00000;
    if (i == 1) return 19'h7FFFF;
    return 19'((i * 104729 + 3) ^ (i << 13));
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs while held in reset
    chk(ready && m_ce_n && m_oe_n && m_we_n && !m_dq_oe && !rvalid, "R1", "reset state",
        {ready, m_ce_n, m_oe_n, m_we_n, m_dq_oe, rvalid}, 6'b111100);
    rst_n = 1'b1;
    @(negedge clk);
    armed = 1'b1;
    chk(ready && m_ce_n && m_oe_n && m_we_n && !m_dq_oe && !rvalid, "R1", "after release",
        {ready, m_ce_n, m_oe_n, m_we_n, m_dq_oe, rvalid}, 6'b111100);

    // unwritten location reads as 0 in the model
    run_op(1'b0, 19'h12345, 8'h00, 1'b0, '0);
    // sweep: writes, then reads in reverse order
    for (int i = 0; i < 48; i++) run_op(1'b1, addr_of(i), 8'(i * 53 + 17), 1'b0, '0);
    for (int i = 47; i >= 0; i--) run_op(1'b0, addr_of(i), 8'h00, 1'b0, '0);
    // back-to-back write/read pairs and read-then-write handovers
    for (int i = 0; i < 32; i++) begin
      run_op(1'b1, addr_of(i + 100), 8'(i * 29 + 200), 1'b0, '0);
      run_op(1'b0, addr_of(i + 100), 8'h00, 1'b0, '0);
      run_op(1'b1, addr_of(i), 8'(~(i * 7)), 1'b0, '0);
      run_op(1'b0, addr_of(i), 8'h00, 1'b0, '0);
    end
    // R2: conflicting write held on req while a read is busy, then withdrawn
    run_op(1'b0, addr_of(5), 8'h3C, 1'b1, 19'h5A5A5);
    run_op(1'b0, 19'h5A5A5, 8'h00, 1'b0, '0);
    chk(mem_rd(19'h5A5A5) == exp_rd(19'h5A5A5), "R2", "busy request left memory unchanged",
        mem_rd(19'h5A5A5), exp_rd(19'h5A5A5));
    repeat (3) @(negedge clk);
    chk(ready && m_ce_n && !m_dq_oe, "R1", "idle after traffic", {ready, m_ce_n, m_dq_oe}, 3'b110);
    finish_run();
  end
endmodule